// File: doc/BRIEF.md
# Two-Input Modulo-4 Ones Counter

This block is a synchronous Moore machine that watches two single-bit inputs. On every rising clock edge it adds the number of inputs that are high (zero, one or two) to a running total kept modulo 4. Its single output is high whenever the total of ones seen since the last reset is a multiple of four. It extends a serial parity checker from a modulo-2 count to a modulo-4 count, taking two input bits per cycle instead of one.

The two state bits are visible at the ports. A build-time parameter selects how they encode the count:

- **Straight binary:** the state bits are the residue itself, and the next state is formed by an adder.
- **Reflected Gray code:** the state is held in two JK-style storage cells, and neighbouring counts differ in one bit.

The output sequence is the same under either encoding. A synchronous, active-high reset returns the machine to the zero-count state.

Top module: `ones_mod4_counter`

## Requirements
- R1: When `rst` is high at a rising edge, the state after that edge is `2'b00` (count zero) and `zero_flag` is 1, whatever the data inputs are.
- R2: When both `in_a` and `in_b` are low at a rising edge and `rst` is low, `state_bits` keeps its value across that edge.
- R3: When exactly one of `in_a`, `in_b` is high at a rising edge and `rst` is low, the count residue advances by one modulo 4 (0→1→2→3→0).
- R4: When both `in_a` and `in_b` are high at a rising edge and `rst` is low, the residue advances by two modulo 4 (0→2, 1→3, 2→0, 3→1).
- R5: `zero_flag` is 1 exactly when the number of high input samples since the last reset is a multiple of four. It is a Moore output and depends on the state only.
- R6: With `USE_GRAY` = 0, `state_bits` equals the residue in binary, with `state_bits[1]` as the high bit.
- R7: With `USE_GRAY` = 1, residues 0, 1, 2, 3 appear on `state_bits` as 00, 01, 11, 10. A single-step advance changes exactly one state bit.
- R8: For any input stream, the two encodings produce the same `zero_flag` sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | First counted input bit |
| in_b | input | 1 | Second counted input bit |
| state_bits | output | 2 | Current state register, encoded as selected by `USE_GRAY` |
| zero_flag | output | 1 | High when the ones count is 0 modulo 4 |

## Verification
The bound assertions check the following on every cycle:
- that reset forces the zero state;
- that an idle input pair holds the state;
- that single and double inputs move the decoded residue by one and two;
- that the flag rises after any step that lands on a zero residue;
- under the Gray build, that a single step changes exactly one state bit.

Only the bench scenarios can show the remaining properties. The bench runs both encodings side by side against a ones-counting model, so it can show:
- that the flag tracks the whole history of the stream, including long idle runs, wrap-around many times over, and a reset that arrives while both inputs are high;
- that the two encodings never disagree on the flag.

// File: rtl/ones_mod4_pkg.sv
package ones_mod4_pkg;

  localparam int IN_N    = 2;
  localparam int STATE_W = 2;
  localparam int MODULUS = 1 << STATE_W;

  typedef logic [STATE_W-1:0] res_t;

  // number of high bits among the two inputs, as a residue step
  function automatic res_t pair_weight(input logic a, input logic b);
    return {a & b, a ^ b};
  endfunction

  // residue to reflected code
  function automatic res_t res_to_gray(input res_t r);
    return r ^ (r >> 1);
  endfunction

  // reflected code to residue
  function automatic res_t gray_to_res(input res_t g);
    return {g[1], g[1] ^ g[0]};
  endfunction

  // decode a state vector under either encoding
  function automatic res_t state_to_res(input res_t s, input bit gray);
    return gray ? gray_to_res(s) : s;
  endfunction

endpackage

// File: rtl/ones_weight.sv
module ones_weight
  import ones_mod4_pkg::*;
#(
  parameter int N_IN = IN_N,
  parameter int W    = STATE_W
) (
  input  logic [N_IN-1:0] bits_in,
  output logic [W-1:0]    weight
);

  always_comb begin
    weight = '0;
    for (int i = 0; i < N_IN; i++) begin
      weight = weight + W'(bits_in[i]);
    end
  end

endmodule

// File: rtl/ones_jk_cell.sv
module ones_jk_cell (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);

  // set when j, clear when k, toggle when both
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= (j & ~q) | (~k & q);
  end

endmodule

// File: rtl/ones_state_core.sv
module ones_state_core
  import ones_mod4_pkg::*;
#(
  parameter bit USE_GRAY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic in_a,
  input  logic in_b,
  input  res_t weight,
  output res_t state_q
);

  generate
    if (USE_GRAY) begin : g_gray
      logic both, any_in;
      logic hi_q, lo_q;
      logic j_hi, k_hi, j_lo, k_lo;

      assign both   = in_a & in_b;
      assign any_in = in_a | in_b;

      // excitation for sequence 00 -> 01 -> 11 -> 10
      assign j_hi = both | (any_in & lo_q);
      assign k_hi = both | (any_in & ~lo_q);
      assign j_lo = both | (any_in & ~hi_q);
      assign k_lo = both | (any_in & hi_q);

      ones_jk_cell u_hi (.clk(clk), .rst(rst), .j(j_hi), .k(k_hi), .q(hi_q));
      ones_jk_cell u_lo (.clk(clk), .rst(rst), .j(j_lo), .k(k_lo), .q(lo_q));

      assign state_q = {hi_q, lo_q};
    end else begin : g_binary
      res_t cnt_q;

      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + weight;
      end

      assign state_q = cnt_q;
    end
  endgenerate

endmodule

// File: rtl/ones_mod4_counter.sv
module ones_mod4_counter
  import ones_mod4_pkg::*;
#(
  parameter bit USE_GRAY = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_a,
  input  logic       in_b,
  output logic [1:0] state_bits,
  output logic       zero_flag
);

  res_t weight;
  res_t state_q;

  ones_weight #(.N_IN(IN_N), .W(STATE_W)) u_weight (
    .bits_in ({in_b, in_a}),
    .weight  (weight)
  );

  ones_state_core #(.USE_GRAY(USE_GRAY)) u_core (
    .clk     (clk),
    .rst     (rst),
    .in_a    (in_a),
    .in_b    (in_b),
    .weight  (weight),
    .state_q (state_q)
  );

  // the zero count is coded 00 in both encodings
  assign state_bits = state_q;
  assign zero_flag  = ~|state_q;

endmodule

// File: rtl/ones_mod4_checker.sv
module ones_mod4_checker
  import ones_mod4_pkg::*;
#(
  parameter bit USE_GRAY = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       in_a,
  input logic       in_b,
  input logic [1:0] state_bits,
  input logic       zero_flag
);

  res_t residue;
  always_comb residue = state_to_res(state_bits, USE_GRAY);

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (state_bits == 2'b00) && zero_flag);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!in_a && !in_b) |=> $stable(state_bits));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    (in_a ^ in_b) |=> residue == res_t'($past(residue) + 2'd1));

  assert_double_step_R4: assert property (@(posedge clk) disable iff (rst)
    (in_a && in_b) |=> residue == res_t'($past(residue) + 2'd2));

  assert_flag_on_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (((residue == 2'd3) && (in_a ^ in_b)) ||
     ((residue == 2'd2) && in_a && in_b)) |=> zero_flag);

  assert_gray_adjacent_R7: assert property (@(posedge clk) disable iff (rst)
    (USE_GRAY && (in_a ^ in_b)) |=>
      $countones(state_bits ^ $past(state_bits)) == 1);

endmodule

bind ones_mod4_counter ones_mod4_checker #(.USE_GRAY(USE_GRAY)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .in_a       (in_a),
  .in_b       (in_b),
  .state_bits (state_bits),
  .zero_flag  (zero_flag)
);

// File: tb/tb_ones_mod4_counter.sv
`timescale 1ns/1ps
module tb_ones_mod4_counter;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 1'b0;
  logic in_b = 1'b0;
  logic [1:0] st_bin, st_gray;
  logic       fl_bin, fl_gray;

  int checks = 0;
  int fails  = 0;
  int ones_seen = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ones_mod4_counter #(.USE_GRAY(1'b0)) dut (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
    .state_bits(st_bin), .zero_flag(fl_bin));

  ones_mod4_counter #(.USE_GRAY(1'b1)) dut_gray (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
    .state_bits(st_gray), .zero_flag(fl_gray));

  function automatic logic [1:0] gray_of(input int r);
    case (r)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // one clock: apply inputs on the falling edge, then compare after the rising edge
  task automatic step(input logic a, input logic b, input logic r);
    string tag;
    int res;
    @(negedge clk);
    in_a = a; in_b = b; rst = r;
    @(posedge clk);
    #1;
    if (r) ones_seen = 0;
    else   ones_seen += int'(a) + int'(b);
    res = ones_seen % 4;
    if (r)             tag = "R1";
    else if (!a && !b) tag = "R2";
    else if (a && b)   tag = "R4";
    else               tag = "R3";
    check({tag, "/R6 binary state"}, st_bin, res);
    check({tag, "/R7 gray state"}, st_gray, gray_of(res));
    check("R5 flag", fl_bin, (res == 0) ? 1 : 0);
    check("R8 encodings agree", fl_gray, fl_bin);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    // R2 idle holds at zero
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0);
    // R3 single steps around the ring twice, each input alone
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b0);
    // R2 idle at a non-zero residue
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);
    // R4 double steps from an odd residue, then from an even one
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0);
    // R1 reset while both inputs are high and the count is non-zero
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    // R5 / R8 mixed stream
    for (int i = 0; i < 400; i++) begin
      int v;
      v = $urandom_range(0, 3);
      step(v[0], v[1], ($urandom_range(0, 63) == 0) ? 1'b1 : 1'b0);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule